// File: doc/BRIEF.md
# Unaligned Store Lane Splitter

This block sits between a byte-addressed store source and a bus whose data path is a fixed number of bytes wide (eight by default). It takes one store at a time, with a start address, a size of 1, 2, 4 or 8 bytes and little-endian data. It turns the store into one or two bus beats. Each beat carries an address on a bus-word boundary, a per-byte lane strobe and data already rotated so that every byte sits in its own lane.

The number of beats depends only on whether the store's bytes spill past the end of a bus word. Natural alignment does not decide it. A misaligned 4-byte store that stays inside one bus word still takes a single beat. Every beat also carries a flag that says whether the store was naturally aligned, so a downstream agent can count or trap misaligned traffic. Both sides use a valid/ready handshake. A new store is not accepted until the final beat of the current one has been taken.

Top module: `store_lane_splitter`

## Requirements
- R1: After reset, `st_ready` is 1 and `bt_valid` is 0. `st_ready` is 0 whenever a beat is pending on the output.
- R2: The first beat's address is the store address with its three low bits cleared. A second beat's address is the first beat's address plus 8.
- R3: `st_size` encodes the byte count as 2^st_size (0=1, 1=2, 2=4, 3=8 bytes). A store whose bytes fit inside one 8-byte bus word produces exactly one beat. That beat's strobe bit k (lane k = data bits 8k+7..8k) is set exactly for the bytes the store covers. Examples: 4 bytes at 0x1001 gives 0x1E, 2 bytes at offset 1 gives 0x06, 8 bytes at 0x1000 gives 0xFF.
- R4: A store that crosses a bus-word boundary produces two beats, the lower word first. For example, 8 bytes at 0x1004 gives strobe 0xF0 at 0x1000, then 0x0F at 0x1008. The second beat's strobe always includes lane 0.
- R5: Store data byte i (bits 8i+7..8i of `st_data`) belongs to address A+i. It appears in lane (A+i) mod 8 of the beat that covers that address.
- R6: Lanes whose strobe bit is clear carry zero. Bytes of `st_data` above the store size have no effect on any beat.
- R7: `bt_last` is 1 on the final beat of a store and 0 on the first beat of a two-beat store. No beat is presented after the last one until a new store is accepted.
- R8: `bt_aligned` is 1 on every beat of a store exactly when the low st_size address bits are zero. A single-byte store is always aligned.
- R9: While `bt_valid` is 1 and `bt_ready` is 0, the beat's address, strobe, data, last and aligned outputs stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| st_valid | input | 1 | A store is offered |
| st_ready | output | 1 | Splitter can take a store |
| st_addr | input | ADDR_W | Byte address of the store's first byte |
| st_size | input | SIZE_W | Log2 of the store's byte count |
| st_data | input | 8*BUS_BYTES | Store data, little-endian, byte 0 in bits 7..0 |
| bt_valid | output | 1 | A beat is presented |
| bt_ready | input | 1 | Bus takes the beat |
| bt_addr | output | ADDR_W | Bus-word aligned beat address |
| bt_strb | output | BUS_BYTES | Lane enables of the beat |
| bt_data | output | 8*BUS_BYTES | Lane-rotated beat data |
| bt_last | output | 1 | Final beat of the store |
| bt_aligned | output | 1 | Store was naturally aligned |

## Verification
Several properties are checked on every cycle: beat addresses sit on bus-word boundaries, a presented beat always has a lane enabled, the input is closed while a beat is pending, a stalled beat holds still, and a non-final beat taken is followed by a beat one word higher that starts at lane 0. The bench's scenarios are needed for the things that depend on the particular store. These are the exact strobe pattern, the byte-to-lane placement, zeroed idle lanes, the beat count, the last flag and the aligned flag. The bench sweeps every size at every offset within a bus word, with and without backpressure, and computes the expected beats arithmetically from the address and size.

// File: rtl/sls_pkg.sv
// Shared types for the store lane splitter.
// Assumes: at most two beats per store (store size never exceeds the bus width).
package sls_pkg;
    typedef enum logic [1:0] {
        SLS_IDLE = 2'd0,   // no store held, input open
        SLS_LOW  = 2'd1,   // presenting the lower (or only) bus word
        SLS_HIGH = 2'd2    // presenting the upper bus word of a crossing store
    } sls_state_e;
endpackage

// File: rtl/sls_lane_plan.sv
// Combinational lane planner: works out, for one byte-addressed store, the
// aligned base address, the strobes and rotated data of the lower and upper
// bus words, whether the store crosses into the upper word, and whether it is
// naturally aligned.
// Assumes: BUS_BYTES is a power of two and 2^size never exceeds BUS_BYTES.
module sls_lane_plan #(
    parameter int BUS_BYTES = 8,
    parameter int ADDR_W    = 32,
    parameter int OFF_W     = $clog2(BUS_BYTES),
    parameter int SIZE_W    = $clog2(OFF_W + 1),
    parameter int DATA_W    = 8 * BUS_BYTES
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [SIZE_W-1:0]    size,
    input  logic [DATA_W-1:0]    data,
    output logic [ADDR_W-1:0]    base_addr,
    output logic [BUS_BYTES-1:0] strb_lo,
    output logic [BUS_BYTES-1:0] strb_hi,
    output logic [DATA_W-1:0]    data_lo,
    output logic [DATA_W-1:0]    data_hi,
    output logic                 crosses,
    output logic                 aligned
);
    localparam int WIDE_B = 2 * BUS_BYTES;

    logic [OFF_W-1:0]     offset;
    logic [OFF_W:0]       nbytes;
    logic [OFF_W:0]       nbytes_m1;
    logic [BUS_BYTES-1:0] len_mask;
    logic [DATA_W-1:0]    data_trim;
    logic [WIDE_B-1:0]    wide_strb;
    logic [2*DATA_W-1:0]  wide_data;

    // Byte offset of the store inside its bus word and its byte count.
    always_comb begin
        offset    = addr[OFF_W-1:0];
        nbytes    = (OFF_W+1)'(1) << size;
        nbytes_m1 = nbytes - (OFF_W+1)'(1);
    end

    // One enable and one trimmed data byte per byte position of the store.
    for (genvar i = 0; i < BUS_BYTES; i++) begin : g_byte
        localparam logic [OFF_W:0] IDX = (OFF_W+1)'(i);
        assign len_mask[i]        = (IDX < nbytes);
        assign data_trim[8*i +: 8] = len_mask[i] ? data[8*i +: 8] : 8'h00;
    end

    // Rotate enables and data across a two-word window by the byte offset.
    always_comb begin
        wide_strb = {{BUS_BYTES{1'b0}}, len_mask} << offset;
        wide_data = {{DATA_W{1'b0}}, data_trim} << {offset, 3'b000};
    end

    // Split the window into the two bus words and derive the flags.
    always_comb begin
        base_addr = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        strb_lo   = wide_strb[BUS_BYTES-1:0];
        strb_hi   = wide_strb[WIDE_B-1:BUS_BYTES];
        data_lo   = wide_data[DATA_W-1:0];
        data_hi   = wide_data[2*DATA_W-1:DATA_W];
        crosses   = |strb_hi;
        aligned   = ((offset & nbytes_m1[OFF_W-1:0]) == {OFF_W{1'b0}});
    end
endmodule

// File: rtl/sls_beat_seq.sv
// Beat sequencer: captures one planned store on acceptance and presents its
// one or two beats in address order, holding each until the bus takes it.
// Assumes: the plan inputs are valid whenever st_valid is high.
module sls_beat_seq
    import sls_pkg::*;
#(
    parameter int BUS_BYTES = 8,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 8 * BUS_BYTES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 st_valid,
    output logic                 st_ready,
    input  logic [ADDR_W-1:0]    plan_base,
    input  logic [BUS_BYTES-1:0] plan_strb_lo,
    input  logic [BUS_BYTES-1:0] plan_strb_hi,
    input  logic [DATA_W-1:0]    plan_data_lo,
    input  logic [DATA_W-1:0]    plan_data_hi,
    input  logic                 plan_crosses,
    input  logic                 plan_aligned,
    output logic                 bt_valid,
    input  logic                 bt_ready,
    output logic [ADDR_W-1:0]    bt_addr,
    output logic [BUS_BYTES-1:0] bt_strb,
    output logic [DATA_W-1:0]    bt_data,
    output logic                 bt_last,
    output logic                 bt_aligned
);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(BUS_BYTES);

    sls_state_e           state;
    logic [ADDR_W-1:0]    hold_base;
    logic [BUS_BYTES-1:0] hold_strb_lo;
    logic [BUS_BYTES-1:0] hold_strb_hi;
    logic [DATA_W-1:0]    hold_data_lo;
    logic [DATA_W-1:0]    hold_data_hi;
    logic                 hold_crosses;
    logic                 hold_aligned;
    logic                 accept;
    logic                 take;

    // Handshake events on each side.
    always_comb begin
        st_ready = (state == SLS_IDLE);
        bt_valid = (state != SLS_IDLE);
        accept   = st_valid && st_ready;
        take     = bt_valid && bt_ready;
    end

    // State walk: idle -> low word -> (upper word) -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SLS_IDLE;
        end else begin
            case (state)
                SLS_IDLE: if (accept) state <= SLS_LOW;
                SLS_LOW:  if (take)   state <= hold_crosses ? SLS_HIGH : SLS_IDLE;
                SLS_HIGH: if (take)   state <= SLS_IDLE;
                default:              state <= SLS_IDLE;
            endcase
        end
    end

    // Capture the planned beats when a store is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_base    <= '0;
            hold_strb_lo <= '0;
            hold_strb_hi <= '0;
            hold_data_lo <= '0;
            hold_data_hi <= '0;
            hold_crosses <= 1'b0;
            hold_aligned <= 1'b0;
        end else if (accept) begin
            hold_base    <= plan_base;
            hold_strb_lo <= plan_strb_lo;
            hold_strb_hi <= plan_strb_hi;
            hold_data_lo <= plan_data_lo;
            hold_data_hi <= plan_data_hi;
            hold_crosses <= plan_crosses;
            hold_aligned <= plan_aligned;
        end
    end

    // Select the beat currently presented.
    always_comb begin
        if (state == SLS_HIGH) begin
            bt_addr = hold_base + WORD_STEP;
            bt_strb = hold_strb_hi;
            bt_data = hold_data_hi;
            bt_last = 1'b1;
        end else begin
            bt_addr = hold_base;
            bt_strb = hold_strb_lo;
            bt_data = hold_data_lo;
            bt_last = !hold_crosses;
        end
        bt_aligned = hold_aligned;
    end

    // R1: input closed while a beat is pending.
    p_closed_when_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bt_valid |-> !st_ready);

    // R2: beat addresses sit on a bus-word boundary.
    p_word_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bt_valid |-> (bt_addr % WORD_STEP) == '0);

    // R2: a taken non-final beat is followed by the next bus word.
    p_next_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !bt_last) |=> (bt_valid && bt_addr == $past(bt_addr) + WORD_STEP));

    // R3: every presented beat enables at least one lane.
    p_some_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bt_valid |-> (bt_strb != '0));

    // R4: the upper beat of a crossing store starts at lane 0.
    p_upper_from_lane0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !bt_last) |=> bt_strb[0]);

    // R9: a stalled beat holds every field.
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bt_valid && !bt_ready) |=>
            (bt_valid && $stable({bt_addr, bt_strb, bt_data, bt_last, bt_aligned})));
endmodule

// File: rtl/store_lane_splitter.sv
// Store lane splitter top: plans the lanes of an incoming byte-addressed store
// and sequences the resulting one or two bus beats.
// Assumes: store sizes are 2^st_size bytes with 2^st_size <= BUS_BYTES.
module store_lane_splitter #(
    parameter int BUS_BYTES = 8,
    parameter int ADDR_W    = 32,
    parameter int OFF_W     = $clog2(BUS_BYTES),
    parameter int SIZE_W    = $clog2(OFF_W + 1),
    parameter int DATA_W    = 8 * BUS_BYTES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 st_valid,
    output logic                 st_ready,
    input  logic [ADDR_W-1:0]    st_addr,
    input  logic [SIZE_W-1:0]    st_size,
    input  logic [DATA_W-1:0]    st_data,
    output logic                 bt_valid,
    input  logic                 bt_ready,
    output logic [ADDR_W-1:0]    bt_addr,
    output logic [BUS_BYTES-1:0] bt_strb,
    output logic [DATA_W-1:0]    bt_data,
    output logic                 bt_last,
    output logic                 bt_aligned
);
    logic [ADDR_W-1:0]    plan_base;
    logic [BUS_BYTES-1:0] plan_strb_lo;
    logic [BUS_BYTES-1:0] plan_strb_hi;
    logic [DATA_W-1:0]    plan_data_lo;
    logic [DATA_W-1:0]    plan_data_hi;
    logic                 plan_crosses;
    logic                 plan_aligned;

    sls_lane_plan #(
        .BUS_BYTES(BUS_BYTES), .ADDR_W(ADDR_W), .OFF_W(OFF_W),
        .SIZE_W(SIZE_W), .DATA_W(DATA_W)
    ) u_plan (
        .addr      (st_addr),
        .size      (st_size),
        .data      (st_data),
        .base_addr (plan_base),
        .strb_lo   (plan_strb_lo),
        .strb_hi   (plan_strb_hi),
        .data_lo   (plan_data_lo),
        .data_hi   (plan_data_hi),
        .crosses   (plan_crosses),
        .aligned   (plan_aligned)
    );

    sls_beat_seq #(
        .BUS_BYTES(BUS_BYTES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .st_valid     (st_valid),
        .st_ready     (st_ready),
        .plan_base    (plan_base),
        .plan_strb_lo (plan_strb_lo),
        .plan_strb_hi (plan_strb_hi),
        .plan_data_lo (plan_data_lo),
        .plan_data_hi (plan_data_hi),
        .plan_crosses (plan_crosses),
        .plan_aligned (plan_aligned),
        .bt_valid     (bt_valid),
        .bt_ready     (bt_ready),
        .bt_addr      (bt_addr),
        .bt_strb      (bt_strb),
        .bt_data      (bt_data),
        .bt_last      (bt_last),
        .bt_aligned   (bt_aligned)
    );
endmodule

// File: tb/store_lane_splitter_test.sv
`timescale 1ns/1ps
// Sweeps every store size at every offset in a bus word, with and without
// backpressure, and compares each beat against an arithmetic model.
module store_lane_splitter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0;
    logic        st_ready;
    logic [31:0] st_addr = '0;
    logic [1:0]  st_size = '0;
    logic [63:0] st_data = '0;
    logic        bt_valid;
    logic        bt_ready = 1'b0;
    logic [31:0] bt_addr;
    logic [7:0]  bt_strb;
    logic [63:0] bt_data;
    logic        bt_last;
    logic        bt_aligned;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    store_lane_splitter uut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_size(st_size), .st_data(st_data),
        .bt_valid(bt_valid), .bt_ready(bt_ready),
        .bt_addr(bt_addr), .bt_strb(bt_strb), .bt_data(bt_data),
        .bt_last(bt_last), .bt_aligned(bt_aligned)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Offer one store and follow all its beats, optionally stalling each one.
    task automatic run_store(input logic [31:0] addr, input logic [1:0] size,
                             input logic [63:0] data, input bit stall);
        logic [7:0]  es [2];
        logic [63:0] ed [2];
        int off = int'(addr & 32'h7);
        int n = 1 << size;
        int nbeats = (off + n > 8) ? 2 : 1;
        bit al = ((addr % n) == 0);
        logic [31:0] base = addr & ~32'h7;
        logic [31:0] p_addr;
        logic [7:0]  p_strb;
        logic [63:0] p_data;
        es[0] = '0; es[1] = '0; ed[0] = '0; ed[1] = '0;
        for (int i = 0; i < n; i++) begin
            int p = off + i;
            es[p/8][p%8] = 1'b1;
            ed[p/8][(p%8)*8 +: 8] = data[i*8 +: 8];
        end
        @(negedge clk);
        check(st_ready === 1'b1, "R1", "ready before store", {63'b0, st_ready}, 64'd1);
        st_valid = 1'b1; st_addr = addr; st_size = size; st_data = data;
        @(posedge clk);
        @(negedge clk);
        st_valid = 1'b0; st_data = 64'hDEAD_BEEF_0BAD_F00D; st_addr = 32'h5;
        for (int b = 0; b < nbeats; b++) begin
            if (stall) begin
                bt_ready = 1'b0;
                p_addr = bt_addr; p_strb = bt_strb; p_data = bt_data;
                @(negedge clk);
                check(bt_valid === 1'b1 && bt_addr === p_addr && bt_strb === p_strb
                      && bt_data === p_data, "R9", "stalled beat held",
                      {bt_addr, 24'b0, bt_strb}, {p_addr, 24'b0, p_strb});
            end
            check(bt_valid === 1'b1, "R7", "beat present", {63'b0, bt_valid}, 64'd1);
            check(st_ready === 1'b0, "R1", "closed while busy", {63'b0, st_ready}, 64'd0);
            check(bt_addr === base + 32'(8*b), "R2", "beat address",
                  {32'b0, bt_addr}, {32'b0, base + 32'(8*b)});
            check(bt_strb === es[b], (nbeats == 2) ? "R4" : "R3", "strobe",
                  {56'b0, bt_strb}, {56'b0, es[b]});
            check(bt_data === ed[b], "R5/R6", "lane data", bt_data, ed[b]);
            check(bt_last === (b == nbeats-1), "R7", "last flag",
                  {63'b0, bt_last}, {63'b0, (b == nbeats-1)});
            check(bt_aligned === al, "R8", "aligned flag",
                  {63'b0, bt_aligned}, {63'b0, al});
            bt_ready = 1'b1;
            @(posedge clk);
            @(negedge clk);
            bt_ready = 1'b0;
        end
        check(bt_valid === 1'b0, "R7", "no beat after last", {63'b0, bt_valid}, 64'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(st_ready === 1'b1, "R1", "reset ready", {63'b0, st_ready}, 64'd1);
        check(bt_valid === 1'b0, "R1", "reset valid", {63'b0, bt_valid}, 64'd0);
        // R3 single-beat examples, R4 crossing example, R6 upper bytes garbage
        run_store(32'h1001, 2'd2, 64'hFFFF_FFFF_4433_2211, 1'b0); // R3 0x1E
        run_store(32'h1001, 2'd1, 64'hAAAA_AAAA_AAAA_BEEF, 1'b0); // R3 0x06
        run_store(32'h1000, 2'd3, 64'h8877_6655_4433_2211, 1'b1); // R3 0xFF
        run_store(32'h1004, 2'd3, 64'h0807_0605_0403_0201, 1'b1); // R4 0xF0, 0x0F
        // Sweep: every size at every offset, alternate stalls.
        for (int s = 0; s < 4; s++) begin
            for (int o = 0; o < 8; o++) begin
                int k = s*8 + o;
                logic [63:0] d = 64'h8877_6655_4433_2211 ^ (64'(k) * 64'h0101_0101_0101_0101)
                                 ^ 64'hF0F0_0000_0000_0000;
                run_store(32'h2000_0000 + 32'(k*16 + o), 2'(s), d, (k % 3) == 1);
            end
        end
        // R2 wrap at top of address space
        run_store(32'hFFFF_FFFE, 2'd2, 64'h0000_0000_DDCC_BBAA, 1'b0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule